// File: doc/BRIEF.md
# Trigger-Indexed Helper Trace Cache

This block keeps a small set of pre-computed helper instruction traces, each tagged with the program counter of a trigger instruction. A loader writes the traces ahead of time, one instruction per cycle, through a dedicated write port. At run time the block watches the main thread's PC stream. When a presented PC equals the tag of a valid entry, it raises a one-cycle fork request naming that entry. It then sends the entry's stored instructions to a helper context, one per cycle, in exactly the order they were written.

The trigger instruction is not stored in the trace body. The body holds only the instructions that follow the trigger in the slice. Sequencing is straight-line: every stored instruction is issued, branches included, and nothing redirects the stream. A stream always stops after the stored length, so a helper cannot run on. Only one trace streams at a time. Triggers that arrive while a stream is in progress are dropped. A flush input aborts a stream at once.

Top module: `helper_trace_cache`

## Requirements
- R1: Each load beat writes one instruction at the next body position of entry `load_slot`. The beat carrying `load_last` completes the entry: it becomes valid, and its length is the number of beats written.
- R2: A load beat written at body position MAX_LEN-1 completes the entry with length MAX_LEN even when `load_last` is low, and the next beat starts a fresh load at position 0.
- R3: A cycle with `pc_valid` high, while idle, whose `pc` equals the tag of a valid entry gives `fork_valid` high with `fork_slot` naming that entry in the next cycle. `busy` is also high in that cycle.
- R4: In the cycles after the fork cycle, the entry's instructions appear on `out_insn`, one per cycle, with `out_valid` high. `out_pos` counts 0, 1, 2 and so on, and the number of instructions issued equals the stored length exactly.
- R5: `done` is high for exactly one cycle, the cycle after the last instruction. In that cycle `busy` and `out_valid` are low.
- R6: Trigger hits presented while `busy` is high are ignored and produce no fork, then or later.
- R7: No fork occurs when `pc_valid` is low or when no valid entry's tag matches.
- R8: When several valid entries carry the same tag, the lowest-numbered entry is the one forked.
- R9: `flush` high in any cycle makes `busy`, `out_valid` and `fork_valid` low in the next cycle, and no `done` pulse follows the aborted stream.
- R10: After reset every entry is invalid, and `busy`, `fork_valid`, `out_valid` and `done` are low.
- R11: From the first beat of a load into an entry until its completing beat, that entry matches no PC, whether the old tag or the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Abort any stream, return to idle |
| load_valid | input | 1 | Load beat present |
| load_slot | input | $clog2(NUM_TRACES) | Entry being loaded |
| load_tag | input | PC_W | Trigger PC, taken on the first beat |
| load_insn | input | INSN_W | Instruction for the next body position |
| load_last | input | 1 | This beat completes the entry |
| pc_valid | input | 1 | Main-thread PC present |
| pc | input | PC_W | Main-thread instruction PC |
| fork_valid | output | 1 | One-cycle fork request |
| fork_slot | output | $clog2(NUM_TRACES) | Entry being forked |
| out_valid | output | 1 | Helper instruction present |
| out_insn | output | INSN_W | Helper instruction (zero when not valid) |
| out_pos | output | $clog2(MAX_LEN) | Body position of out_insn |
| busy | output | 1 | Fork or stream in progress |
| done | output | 1 | One-cycle pulse after the last instruction |

## Verification
The bench builds the block with four entries, an 8-instruction body limit and 16-bit PCs and instructions. At these sizes a full-length trace takes only eight stream cycles, so the forced completion at the length limit can be reached directly, as can a one-instruction trace. Four entries are enough to place two entries with the same tag in one test and check that the lowest-numbered one wins. They also allow one entry to be reloaded while another keeps its contents.

// File: rtl/htc_pkg.sv
// Shared types for the helper trace cache.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package htc_pkg;

    // Sequencer states: idle, one fork cycle, then the stream.
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_FORK   = 2'd1,
        SEQ_STREAM = 2'd2
    } seq_state_e;

endpackage

// File: rtl/htc_store.sv
// Trace storage and loader.
// Holds per-entry valid bit, trigger tag and length, plus the body memory.
// The loader writes one instruction per beat at an internal position
// counter. The first beat of a load invalidates the entry and takes the tag.
// A last flag, or reaching the body limit, completes the entry.
// Assumes load_slot stays the same for all beats of one load, and that a
// trace being streamed is not reloaded at the same time.
module htc_store #(
    parameter int NUM_TRACES = 16,
    parameter int MAX_LEN    = 32,
    parameter int PC_W       = 32,
    parameter int INSN_W     = 32,
    localparam int IDX_W     = $clog2(NUM_TRACES),
    localparam int POS_W     = $clog2(MAX_LEN),
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_valid,
    input  logic [IDX_W-1:0]           ld_slot,
    input  logic [PC_W-1:0]            ld_tag,
    input  logic [INSN_W-1:0]          ld_insn,
    input  logic                       ld_last,
    output logic [NUM_TRACES-1:0]      ent_valid,
    output logic [NUM_TRACES*PC_W-1:0] ent_tags,
    input  logic [IDX_W-1:0]           rd_slot,
    input  logic [POS_W-1:0]           rd_pos,
    output logic [LEN_W-1:0]           rd_len,
    output logic [INSN_W-1:0]          rd_insn
);

    logic [INSN_W-1:0] body_mem [NUM_TRACES][MAX_LEN];
    logic [LEN_W-1:0]  ent_len  [NUM_TRACES];
    logic [POS_W-1:0]  wr_pos;
    logic              wr_close;

    // A beat closes the entry on the last flag or at the final body position.
    assign wr_close = ld_last || (wr_pos == POS_W'(MAX_LEN - 1));

    // Advance the body write position, wrapping after a closing beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pos <= '0;
        end else if (ld_valid) begin
            if (wr_close) wr_pos <= '0;
            else          wr_pos <= wr_pos + 1'b1;
        end
    end

    // Write the instruction of each beat into the body memory.
    always_ff @(posedge clk) begin
        if (ld_valid) body_mem[ld_slot][wr_pos] <= ld_insn;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_TRACES; g++) begin : g_meta
            logic [PC_W-1:0] tag_q;
            logic            valid_q;
            logic [LEN_W-1:0] len_q;

            // Keep this entry's tag, length and valid bit up to date.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q <= 1'b0;
                    tag_q   <= '0;
                    len_q   <= '0;
                end else if (ld_valid && (ld_slot == IDX_W'(g))) begin
                    if (wr_pos == '0) begin
                        valid_q <= 1'b0;
                        tag_q   <= ld_tag;
                    end
                    if (wr_close) begin
                        valid_q <= 1'b1;
                        len_q   <= LEN_W'(wr_pos) + 1'b1;
                    end
                end
            end

            assign ent_valid[g]               = valid_q;
            assign ent_tags[g*PC_W +: PC_W]   = tag_q;
            assign ent_len[g]                 = len_q;
        end
    endgenerate

    // Read port used by the sequencer.
    assign rd_len  = ent_len[rd_slot];
    assign rd_insn = body_mem[rd_slot][rd_pos];

endmodule

// File: rtl/htc_match.sv
// Trigger matcher.
// Compares the presented PC with every valid tag in parallel and returns
// the lowest-numbered matching entry. Purely combinational.
module htc_match #(
    parameter int NUM_TRACES = 16,
    parameter int PC_W       = 32,
    localparam int IDX_W     = $clog2(NUM_TRACES)
) (
    input  logic                       pc_valid,
    input  logic [PC_W-1:0]            pc,
    input  logic [NUM_TRACES-1:0]      ent_valid,
    input  logic [NUM_TRACES*PC_W-1:0] ent_tags,
    output logic                       hit,
    output logic [IDX_W-1:0]           hit_slot
);

    logic [NUM_TRACES-1:0] match_vec;

    genvar g;
    generate
        for (g = 0; g < NUM_TRACES; g++) begin : g_cmp
            // One comparator per entry.
            assign match_vec[g] = pc_valid && ent_valid[g] &&
                                  (ent_tags[g*PC_W +: PC_W] == pc);
        end
    endgenerate

    // Priority pick: scan downward so the lowest index is the last to win.
    always_comb begin
        hit_slot = '0;
        for (int i = NUM_TRACES - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_slot = IDX_W'(i);
        end
    end

    assign hit = |match_vec;

endmodule

// File: rtl/htc_seq.sv
// Stream sequencer.
// Idle until a hit, then one fork cycle, then one body instruction per
// cycle up to the captured length, then a done pulse. Hits are taken only
// while idle. Flush overrides everything. Assumes stored lengths are >= 1.
module htc_seq
    import htc_pkg::*;
#(
    parameter int NUM_TRACES = 16,
    parameter int MAX_LEN    = 32,
    localparam int IDX_W     = $clog2(NUM_TRACES),
    localparam int POS_W     = $clog2(MAX_LEN),
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_slot,
    input  logic [LEN_W-1:0] rd_len,
    output logic [IDX_W-1:0] rd_slot,
    output logic [POS_W-1:0] rd_pos,
    output logic             fork_valid,
    output logic [IDX_W-1:0] fork_slot,
    output logic             out_valid,
    output logic [POS_W-1:0] out_pos,
    output logic             busy,
    output logic             done
);

    seq_state_e       state_q;
    logic [IDX_W-1:0] slot_q;
    logic [POS_W-1:0] pos_q;
    logic [LEN_W-1:0] len_q;
    logic             done_q;
    logic             at_last;

    assign at_last = ((LEN_W'(pos_q) + 1'b1) == len_q);

    // State, slot, position and length registers of the stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            slot_q  <= '0;
            pos_q   <= '0;
            len_q   <= '0;
            done_q  <= 1'b0;
        end else if (flush) begin
            state_q <= SEQ_IDLE;
            pos_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (hit) begin
                        state_q <= SEQ_FORK;
                        slot_q  <= hit_slot;
                        len_q   <= rd_len;
                        pos_q   <= '0;
                    end
                end
                SEQ_FORK: begin
                    state_q <= SEQ_STREAM;
                end
                SEQ_STREAM: begin
                    if (at_last) begin
                        state_q <= SEQ_IDLE;
                        pos_q   <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Read address: the candidate entry while idle, the active one otherwise.
    assign rd_slot    = (state_q == SEQ_IDLE) ? hit_slot : slot_q;
    assign rd_pos     = pos_q;

    // Output decode.
    assign fork_valid = (state_q == SEQ_FORK);
    assign fork_slot  = slot_q;
    assign out_valid  = (state_q == SEQ_STREAM);
    assign out_pos    = pos_q;
    assign busy       = (state_q != SEQ_IDLE);
    assign done       = done_q;

endmodule

// File: rtl/helper_trace_cache.sv
// Trigger-indexed helper trace cache, top level.
// Connects storage, matcher and sequencer. The output instruction is
// forced to zero outside stream cycles.
module helper_trace_cache #(
    parameter int NUM_TRACES = 16,
    parameter int MAX_LEN    = 32,
    parameter int PC_W       = 32,
    parameter int INSN_W     = 32,
    localparam int IDX_W     = $clog2(NUM_TRACES),
    localparam int POS_W     = $clog2(MAX_LEN),
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load_valid,
    input  logic [IDX_W-1:0]  load_slot,
    input  logic [PC_W-1:0]   load_tag,
    input  logic [INSN_W-1:0] load_insn,
    input  logic              load_last,
    input  logic              pc_valid,
    input  logic [PC_W-1:0]   pc,
    output logic              fork_valid,
    output logic [IDX_W-1:0]  fork_slot,
    output logic              out_valid,
    output logic [INSN_W-1:0] out_insn,
    output logic [POS_W-1:0]  out_pos,
    output logic              busy,
    output logic              done
);

    logic [NUM_TRACES-1:0]      ent_valid;
    logic [NUM_TRACES*PC_W-1:0] ent_tags;
    logic                       hit;
    logic [IDX_W-1:0]           hit_slot;
    logic [IDX_W-1:0]           rd_slot;
    logic [POS_W-1:0]           rd_pos;
    logic [LEN_W-1:0]           rd_len;
    logic [INSN_W-1:0]          rd_insn;

    htc_store #(
        .NUM_TRACES(NUM_TRACES), .MAX_LEN(MAX_LEN),
        .PC_W(PC_W), .INSN_W(INSN_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(load_valid), .ld_slot(load_slot), .ld_tag(load_tag),
        .ld_insn(load_insn), .ld_last(load_last),
        .ent_valid(ent_valid), .ent_tags(ent_tags),
        .rd_slot(rd_slot), .rd_pos(rd_pos),
        .rd_len(rd_len), .rd_insn(rd_insn)
    );

    htc_match #(
        .NUM_TRACES(NUM_TRACES), .PC_W(PC_W)
    ) u_match (
        .pc_valid(pc_valid), .pc(pc),
        .ent_valid(ent_valid), .ent_tags(ent_tags),
        .hit(hit), .hit_slot(hit_slot)
    );

    htc_seq #(
        .NUM_TRACES(NUM_TRACES), .MAX_LEN(MAX_LEN)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .hit(hit), .hit_slot(hit_slot), .rd_len(rd_len),
        .rd_slot(rd_slot), .rd_pos(rd_pos),
        .fork_valid(fork_valid), .fork_slot(fork_slot),
        .out_valid(out_valid), .out_pos(out_pos),
        .busy(busy), .done(done)
    );

    // Zero the instruction bus outside stream cycles.
    assign out_insn = out_valid ? rd_insn : '0;

endmodule

// File: rtl/helper_trace_cache_chk.sv
// Protocol checker for helper_trace_cache, attached by bind.
// Observes top-level ports only.
module helper_trace_cache_chk #(
    parameter int IDX_W = 4,
    parameter int POS_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             fork_valid,
    input logic [IDX_W-1:0] fork_slot,
    input logic             out_valid,
    input logic [POS_W-1:0] out_pos,
    input logic             busy,
    input logic             done
);

    // A fork cycle is a busy cycle (R3).
    assert_fork_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fork_valid |-> busy);

    // A fork is followed by stream position 0 unless flushed (R4).
    assert_fork_then_stream_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fork_valid && !flush) |=> (out_valid && out_pos == '0));

    // Consecutive stream cycles step the position by one (R4).
    assert_pos_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_pos == $past(out_pos) + 1'b1));

    // Stream cycles are busy and never overlap the fork cycle (R4).
    assert_stream_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (busy && !fork_valid));

    // Done follows a stream cycle and comes with the block idle (R5).
    assert_done_after_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(out_valid) && !busy && !out_valid));

    // Done lasts one cycle (R5).
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // No new fork can start from a busy cycle (R6).
    assert_no_fork_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !fork_valid);

    // Flush returns to idle in one cycle with no done (R9).
    assert_flush_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!busy && !out_valid && !fork_valid && !done));

endmodule

bind helper_trace_cache helper_trace_cache_chk #(
    .IDX_W(IDX_W), .POS_W(POS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fork_valid(fork_valid), .fork_slot(fork_slot),
    .out_valid(out_valid), .out_pos(out_pos),
    .busy(busy), .done(done)
);

// File: tb/sim_helper_trace_cache.sv
// Directed bench for helper_trace_cache. Inputs change and outputs are
// sampled on the falling edge.
module sim_helper_trace_cache;

    localparam int CLK_PERIOD = 10;
    localparam int NT  = 4;
    localparam int ML  = 8;
    localparam int PW  = 16;
    localparam int IW  = 16;
    localparam int IXW = $clog2(NT);
    localparam int PSW = $clog2(ML);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           flush = 1'b0;
    logic           load_valid = 1'b0;
    logic [IXW-1:0] load_slot = '0;
    logic [PW-1:0]  load_tag = '0;
    logic [IW-1:0]  load_insn = '0;
    logic           load_last = 1'b0;
    logic           pc_valid = 1'b0;
    logic [PW-1:0]  pc = '0;
    logic           fork_valid;
    logic [IXW-1:0] fork_slot;
    logic           out_valid;
    logic [IW-1:0]  out_insn;
    logic [PSW-1:0] out_pos;
    logic           busy;
    logic           done;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    helper_trace_cache #(
        .NUM_TRACES(NT), .MAX_LEN(ML), .PC_W(PW), .INSN_W(IW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .load_valid(load_valid), .load_slot(load_slot), .load_tag(load_tag),
        .load_insn(load_insn), .load_last(load_last),
        .pc_valid(pc_valid), .pc(pc),
        .fork_valid(fork_valid), .fork_slot(fork_slot),
        .out_valid(out_valid), .out_insn(out_insn), .out_pos(out_pos),
        .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_checks = n_checks + 1;
            n_fails  = n_fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Send load beats from position 'start'; last flag on the final beat if asked.
    task automatic load_beats(input int slot, input int tag, input int base,
                              input int start, input int n, input bit with_last);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            load_valid = 1'b1;
            load_slot  = IXW'(slot);
            load_tag   = PW'(tag);
            load_insn  = IW'(base + start + i);
            load_last  = with_last && (i == n - 1);
        end
        @(negedge clk);
        load_valid = 1'b0;
        load_last  = 1'b0;
    endtask

    // Present one trigger PC and check the fork, the full stream and done.
    task automatic run_stream(input int tag, input int slot, input int base,
                              input int n, input string req);
        @(negedge clk);
        pc_valid = 1'b1;
        pc       = PW'(tag);
        @(negedge clk);
        pc_valid = 1'b0;
        check(fork_valid === 1'b1, {req, " R3 fork_valid"}, int'(fork_valid), 1);
        check(fork_slot == IXW'(slot), {req, " R3 fork_slot"}, int'(fork_slot), slot);
        check(busy === 1'b1 && out_valid === 1'b0, {req, " R3 busy in fork"}, int'(busy), 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(out_valid === 1'b1, {req, " R4 out_valid"}, int'(out_valid), 1);
            check(out_insn == IW'(base + i), {req, " R4 out_insn"}, int'(out_insn), base + i);
            check(out_pos == PSW'(i), {req, " R4 out_pos"}, int'(out_pos), i);
        end
        @(negedge clk);
        check(done === 1'b1 && busy === 1'b0 && out_valid === 1'b0,
              {req, " R5 done after last"}, int'({done, busy, out_valid}), 4);
        @(negedge clk);
        check(done === 1'b0, {req, " R5 done one cycle"}, int'(done), 0);
    endtask

    // Present a PC for several cycles and expect no fork at all.
    task automatic expect_no_fork(input bit v, input int tag, input string req);
        int seen = 0;
        @(negedge clk);
        pc_valid = v;
        pc       = PW'(tag);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (fork_valid || busy) seen = seen + 1;
        end
        pc_valid = 1'b0;
        @(negedge clk);
        if (fork_valid || busy) seen = seen + 1;
        check(seen == 0, req, seen, 0);
    endtask

    task automatic t_reset();
        check(busy === 1'b0 && fork_valid === 1'b0 && out_valid === 1'b0 && done === 1'b0,
              "R10 outputs low after reset", int'({busy, fork_valid, out_valid, done}), 0);
        expect_no_fork(1'b1, 0, "R10 all entries invalid (pc 0)");
    endtask

    task automatic t_basic();
        load_beats(1, 16'h0100, 16'h1100, 0, 3, 1'b1);   // R1
        run_stream(16'h0100, 1, 16'h1100, 3, "basic");
        load_beats(3, 16'h0400, 16'h3400, 0, 1, 1'b1);   // R1 single-beat entry
        run_stream(16'h0400, 3, 16'h3400, 1, "len1");
    endtask

    task automatic t_no_hit();
        expect_no_fork(1'b1, 16'h0200, "R7 unmatched pc");
        expect_no_fork(1'b0, 16'h0100, "R7 pc_valid low");
    endtask

    task automatic t_busy_ignore();
        int seen = 0;
        @(negedge clk);
        pc_valid = 1'b1;
        pc       = 16'h0100;
        @(negedge clk);
        pc       = 16'h0400;    // other valid tag, arrives while busy
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (fork_valid) seen = seen + 1;
        end
        pc_valid = 1'b0;        // last stream cycle done here
        @(negedge clk);
        check(done === 1'b1, "R6 stream completes despite hits", int'(done), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (fork_valid || busy) seen = seen + 1;
        end
        check(seen == 0, "R6 hits while busy ignored", seen, 0);
    endtask

    task automatic t_max_len();
        load_beats(2, 16'h0300, 16'h2300, 0, ML, 1'b0);   // R2 no last flag
        run_stream(16'h0300, 2, 16'h2300, ML, "R2 forced close");
        load_beats(2, 16'h0310, 16'h2500, 0, 2, 1'b1);    // R2 next load restarts at 0
        run_stream(16'h0310, 2, 16'h2500, 2, "R2 restart");
    endtask

    task automatic t_priority();
        load_beats(0, 16'h0310, 16'h0A00, 0, 4, 1'b1);
        run_stream(16'h0310, 0, 16'h0A00, 4, "R8 lowest index");
    endtask

    task automatic t_reload();
        load_beats(1, 16'h0150, 16'h1500, 0, 1, 1'b0);    // open load, not complete
        expect_no_fork(1'b1, 16'h0100, "R11 old tag blocked");
        expect_no_fork(1'b1, 16'h0150, "R11 new tag blocked");
        load_beats(1, 16'h0150, 16'h1500, 1, 4, 1'b1);
        run_stream(16'h0150, 1, 16'h1500, 5, "R11 after reload");
    endtask

    task automatic t_flush();
        int seen = 0;
        @(negedge clk);
        pc_valid = 1'b1;
        pc       = 16'h0150;
        @(negedge clk);
        pc_valid = 1'b0;
        @(negedge clk);         // stream pos 0
        @(negedge clk);         // stream pos 1
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        check(busy === 1'b0 && out_valid === 1'b0, "R9 idle after flush",
              int'({busy, out_valid}), 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (done || busy) seen = seen + 1;
        end
        check(seen == 0, "R9 no done after flush", seen, 0);
        run_stream(16'h0150, 1, 16'h1500, 5, "R9 usable after flush");
    endtask

    initial begin
        idle_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_no_hit();
        t_busy_ignore();
        t_max_len();
        t_priority();
        t_reload();
        t_flush();
        idle_cycles(2);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule